// File: doc/BRIEF.md
# Packet Page Allocation and Queue Manager

This block looks after a small pool of fixed-size packet pages for a network controller. It records which pages are in use in a bitmap. It also keeps three short FIFO queues of page numbers: pages waiting to transmit, pages whose transmission has finished, and pages holding received frames. The packet memory, the MAC and the rest of the register map sit outside the block.

Software drives the block through a command byte. The operation is carried in the top three bits of that byte. Software also writes a page-number register, an interrupt mask and an interrupt acknowledge byte. The block returns the following for register readback:

- the allocation result
- the head of the completion queue
- the head of the receive queue
- the number of pages in use
- the interrupt status and mask

It drives one interrupt line.

The MAC side uses two handshakes. It asks for a receive page with `rx_req` and gets the lowest free page back on `rx_page`. It reports the end of a transmission with `tx_complete`, which retires the head of the transmit queue.

A transmit allocation that cannot be met is held as pending. Every later page release retries it in the same cycle.

Top module: `pkt_page_mgr`

## Requirements
- R1: After reset the following hold: no page is in use, all three queues are empty, `alloc_result` is 0x00, both queue heads read 0x80, `int_status` is 0x04, `int_mask` is 0x00 and `irq` is low.
- R2: An allocate command takes the lowest-numbered free page. It loads that page number into `alloc_result`, sets status bit 3 and raises `pages_used` by one.
- R3: An allocate command first writes 0x80 to `alloc_result` and clears status bit 3. If no page is free, the result stays 0x80 and the allocation is pending. While `alloc_result` is 0x80, any page release retries the allocation in the same cycle. A successful retry loads the page number and sets bit 3.
- R4: The command code is bits [7:5] of `cmd_byte`, as follows:
  - 0: does nothing.
  - 1: allocate a page for transmit.
  - 2: reset the allocator.
  - 3: pop the receive queue.
  - 4: pop the receive queue and release its head page.
  - 5: release the page named by `pnum`.
  - 6: push `pnum` onto the transmit queue.
  - 7: clear the transmit and completion queues.
- R5: A release or transmit push is ignored when `pnum` is 4 or more. A valid release frees that page.
- R6: `tx_complete` with a non-empty transmit queue pops its head. If `auto_release` is 0, that page number is appended to the completion queue. If `auto_release` is 1, the page is freed at once and the completion queue is left unchanged. A push onto a full queue is ignored.
- R7: An empty completion queue or receive queue reads back as 0x80 at its head. A pop of an empty queue changes nothing.
- R8: `rx_ack` is high with `rx_req` only when a page is free and the receive queue has room. An accepted request takes the lowest free page, shows it on `rx_page`, appends it to the receive queue and sets status bit 0.
- R9: A receive-queue pop keeps status bit 0 set if entries remain and clears it if the queue becomes empty. Command 4 also frees the popped page.
- R10: Status bit 2 is 1 whenever the transmit queue is empty. Status bit 1 is 1 whenever the completion queue is non-empty.
- R11: An acknowledge clears the status bits given by (`ack_byte` AND 0xD6). If `ack_byte` bit 1 is set, it also pops the completion-queue head.
- R12: `irq` is high exactly when (`int_status` AND `int_mask`) is non-zero.
- R13: Command 2 frees every page, empties all queues and sets `alloc_result` to 0x00. Command 7 empties only the transmit and completion queues and keeps the page bitmap.
- R14: Events in one cycle are served in a fixed priority order:
  - `cmd_we` first. When it is high, an acknowledge, `tx_complete` and `rx_req` in that cycle are ignored.
  - `ack_we` next. When it is high, `tx_complete` and `rx_req` are ignored.
  - `tx_complete` next. When it fires, `rx_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte, operation in [7:5] |
| pnum_we | input | 1 | Page-number register write strobe |
| pnum_wdata | input | 8 | Page-number write data |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_byte | input | 8 | Acknowledge bits |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | Interrupt mask data |
| auto_release | input | 1 | Free pages on transmit completion |
| tx_complete | input | 1 | MAC finished the transmit-queue head |
| rx_req | input | 1 | MAC asks for a receive page |
| rx_ack | output | 1 | Receive page granted this cycle |
| rx_page | output | 2 | Page granted to the receiver |
| tx_pending | output | 1 | Transmit queue non-empty |
| tx_page | output | 2 | Transmit queue head |
| pnum | output | 8 | Page-number register |
| alloc_result | output | 8 | Allocation result, 0x80 if pending |
| done_head | output | 8 | Completion queue head or 0x80 |
| rx_head | output | 8 | Receive queue head or 0x80 |
| pages_used | output | 3 | Pages currently allocated |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |

## Verification
A wrong bitmap shows up on `pages_used` in the cycle after the faulty allocate or release. It also shows up on the next `alloc_result` or `rx_page`, because lowest-free selection exposes exactly which pages the block believes are taken. A broken shift in a queue appears as a wrong head value as soon as the queue is popped. A missed forced status bit or a wrong acknowledge mask shows on `int_status`, and on `irq` with a suitable mask, one cycle after the event. An exhaustive sweep over all sixteen occupancy patterns, and over every mask value, makes these faults visible within a few commands.

// File: rtl/pba_pkg.sv
`timescale 1ns/1ps
package pba_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_TXALLOC  = 3'd1,
    OP_RESET    = 3'd2,
    OP_RXPOP    = 3'd3,
    OP_RXPOPREL = 3'd4,
    OP_RELEASE  = 3'd5,
    OP_TXPUSH   = 3'd6,
    OP_TXCLR    = 3'd7
  } op_e;

  localparam logic [7:0] EMPTY_CODE = 8'h80;
  localparam logic [7:0] ACK_MASK   = 8'hD6;

  localparam int IRQ_RX      = 0;
  localparam int IRQ_TXDONE  = 1;
  localparam int IRQ_TXEMPTY = 2;
  localparam int IRQ_ALLOC   = 3;

  localparam int OP_LSB = 5;

endpackage

// File: rtl/pba_queue.sv
`timescale 1ns/1ps
module pba_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] ent_q [DEPTH];
  logic [DW-1:0] ent_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d, base;
  logic          do_pop, do_push, ent_en;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    do_push = push && ((cnt_q != FULL_CNT) || do_pop);
    base    = do_pop ? (cnt_q - CW'(1)) : cnt_q;
    if (clr)
      cnt_d = '0;
    else
      cnt_d = cnt_q - CW'(do_pop) + CW'(do_push);
    ent_en = do_pop || do_push;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] shifted;
    if (i < DEPTH - 1) begin : g_mid
      assign shifted = do_pop ? ent_q[i+1] : ent_q[i];
    end else begin : g_last
      assign shifted = ent_q[i];
    end
    assign ent_d[i] = (do_push && (base == CW'(i))) ? push_data : shifted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (ent_en && !clr) begin
        for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
      end
    end
  end

  assign head    = ent_q[0];
  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;

  // R7
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R7
  q_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !clr && cnt_q == '0) |=> (cnt_q == '0));

  // R6
  q_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr && cnt_q == FULL_CNT) |=> (cnt_q == FULL_CNT && $stable(head)));

endmodule

// File: rtl/pba_pool.sv
`timescale 1ns/1ps
module pba_pool #(
  parameter int NUM_PAGES = 4,
  parameter int PW        = 2,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_idx,
  input  logic          alloc_en,
  output logic          alloc_ok,
  output logic [PW-1:0] alloc_idx,
  output logic          any_free,
  output logic [CW-1:0] used_cnt
);

  typedef logic [NUM_PAGES-1:0] map_t;

  map_t          map_q, map_d, map_rel, rel_mask, grant_mask;
  logic          found, map_en;
  logic [PW-1:0] pick;

  always_comb begin
    rel_mask = '0;
    if (rel_en) rel_mask[rel_idx] = 1'b1;
    map_rel = map_q & ~rel_mask;
    found   = 1'b0;
    pick    = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!map_rel[i]) begin
        found = 1'b1;
        pick  = PW'(i);
      end
    end
    alloc_ok   = alloc_en && found;
    alloc_idx  = pick;
    grant_mask = '0;
    if (alloc_ok) grant_mask[pick] = 1'b1;
    map_d  = clr ? '0 : (map_rel | grant_mask);
    map_en = clr || rel_en || alloc_ok;
  end

  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < NUM_PAGES; i++) used_cnt = used_cnt + CW'(map_q[i]);
  end

  assign any_free = ~&map_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      map_q <= '0;
    else if (map_en)
      map_q <= map_d;
  end

  // R2
  alloc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok && !clr) |=> map_q[$past(alloc_idx)]);

  // R5
  release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !alloc_ok && !clr) |=> !map_q[$past(rel_idx)]);

endmodule

// File: rtl/pba_irq.sv
`timescale 1ns/1ps
module pba_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_vec,
  input  logic [7:0] clr_vec,
  input  logic [7:0] force_vec,
  input  logic       mask_we,
  input  logic [7:0] mask_data,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);

  import pba_pkg::*;

  logic [7:0] status_q, status_d, mask_q;
  logic       status_en;

  always_comb begin
    status_d  = ((status_q & ~clr_vec) | set_vec) | force_vec;
    status_en = |(status_d ^ status_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 8'h04;
      mask_q   <= 8'h00;
    end else begin
      if (status_en) status_q <= status_d;
      if (mask_we)   mask_q   <= mask_data;
    end
  end

  assign status = status_q;
  assign mask   = mask_q;
  assign irq    = |(status_q & mask_q);

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec[IRQ_ALLOC] && !set_vec[IRQ_ALLOC] && !force_vec[IRQ_ALLOC])
      |=> !status_q[IRQ_ALLOC]);

endmodule

// File: rtl/pkt_page_mgr.sv
`timescale 1ns/1ps
module pkt_page_mgr #(
  parameter int NUM_PAGES = 4,
  parameter int PW        = $clog2(NUM_PAGES),
  parameter int CW        = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_byte,
  input  logic          pnum_we,
  input  logic [7:0]    pnum_wdata,
  input  logic          ack_we,
  input  logic [7:0]    ack_byte,
  input  logic          mask_we,
  input  logic [7:0]    mask_byte,
  input  logic          auto_release,
  input  logic          tx_complete,
  input  logic          rx_req,
  output logic          rx_ack,
  output logic [PW-1:0] rx_page,
  output logic          tx_pending,
  output logic [PW-1:0] tx_page,
  output logic [7:0]    pnum,
  output logic [7:0]    alloc_result,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [CW-1:0] pages_used,
  output logic [7:0]    int_status,
  output logic [7:0]    int_mask,
  output logic          irq
);

  import pba_pkg::*;

  localparam logic [CW-1:0] FULL_CNT = CW'(NUM_PAGES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  op_e           op;
  logic [7:0]    pnum_q, res_q, res_d;
  logic          pnum_ok, tx_fire, rx_grant, tx_try, res_empty, res_zero;
  logic          pool_clr, pool_rel, pool_alloc, pool_ok, pool_free;
  logic [PW-1:0] pool_rel_idx, pool_idx;
  logic          txq_clr, txq_push, txq_pop;
  logic          dnq_clr, dnq_push, dnq_pop;
  logic          rxq_clr, rxq_pop;
  logic [PW-1:0] txq_head, dnq_head, rxq_head;
  logic [CW-1:0] txq_cnt, dnq_cnt, rxq_cnt, txq_nxt, dnq_nxt, rxq_nxt;
  logic [7:0]    irq_set_a, irq_set, irq_clr, irq_force;

  assign op       = op_e'(cmd_byte[7:OP_LSB]);
  assign pnum_ok  = pnum_q < 8'(NUM_PAGES);
  assign tx_fire  = tx_complete && !cmd_we && !ack_we && (txq_cnt != '0);
  assign rx_grant = rx_req && !cmd_we && !ack_we && !tx_fire && pool_free &&
                    (rxq_cnt != FULL_CNT);

  // command, acknowledge and completion decode
  always_comb begin
    pool_clr     = 1'b0;
    pool_rel     = 1'b0;
    pool_rel_idx = '0;
    tx_try       = 1'b0;
    res_empty    = 1'b0;
    res_zero     = 1'b0;
    txq_clr      = 1'b0;
    txq_push     = 1'b0;
    txq_pop      = 1'b0;
    dnq_clr      = 1'b0;
    dnq_push     = 1'b0;
    dnq_pop      = 1'b0;
    rxq_clr      = 1'b0;
    rxq_pop      = 1'b0;
    irq_set_a    = '0;
    irq_clr      = '0;
    if (cmd_we) begin
      case (op)
        OP_TXALLOC: begin
          res_empty          = 1'b1;
          irq_clr[IRQ_ALLOC] = 1'b1;
          tx_try             = 1'b1;
        end
        OP_RESET: begin
          pool_clr = 1'b1;
          txq_clr  = 1'b1;
          dnq_clr  = 1'b1;
          rxq_clr  = 1'b1;
          res_zero = 1'b1;
        end
        OP_RXPOP, OP_RXPOPREL: begin
          if (rxq_cnt != '0) begin
            rxq_pop = 1'b1;
            if (rxq_cnt > CW'(1)) irq_set_a[IRQ_RX] = 1'b1;
            else                  irq_clr[IRQ_RX]   = 1'b1;
            if (op == OP_RXPOPREL) begin
              pool_rel     = 1'b1;
              pool_rel_idx = rxq_head;
            end
          end
        end
        OP_RELEASE: begin
          if (pnum_ok) begin
            pool_rel     = 1'b1;
            pool_rel_idx = pnum_q[PW-1:0];
          end
        end
        OP_TXPUSH: txq_push = pnum_ok;
        OP_TXCLR: begin
          txq_clr = 1'b1;
          dnq_clr = 1'b1;
        end
        default: ;
      endcase
    end else if (ack_we) begin
      irq_clr = ack_byte & ACK_MASK;
      dnq_pop = ack_byte[IRQ_TXDONE];
    end else if (tx_fire) begin
      txq_pop = 1'b1;
      if (auto_release) begin
        pool_rel     = 1'b1;
        pool_rel_idx = txq_head;
      end else begin
        dnq_push = 1'b1;
      end
    end
    if (pool_rel && (res_q == EMPTY_CODE)) tx_try = 1'b1;
  end

  assign pool_alloc = tx_try || rx_grant;

  // allocation result and interrupt set terms
  always_comb begin
    res_d = res_q;
    if (res_empty) res_d = EMPTY_CODE;
    if (tx_try && pool_ok) res_d = 8'(pool_idx);
    if (res_zero) res_d = 8'h00;
    irq_set = irq_set_a;
    if (tx_try && pool_ok) irq_set[IRQ_ALLOC] = 1'b1;
    if (rx_grant)          irq_set[IRQ_RX]    = 1'b1;
    irq_force = '0;
    irq_force[IRQ_TXEMPTY] = (txq_nxt == '0);
    irq_force[IRQ_TXDONE]  = (dnq_nxt != '0);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_q  <= 8'h00;
      pnum_q <= 8'h00;
    end else begin
      if (res_d != res_q) res_q  <= res_d;
      if (pnum_we)        pnum_q <= pnum_wdata;
    end
  end

  pba_pool #(.NUM_PAGES(NUM_PAGES), .PW(PW), .CW(CW)) u_pool (
    .clk(clk), .rst_n(rst_s), .clr(pool_clr), .rel_en(pool_rel),
    .rel_idx(pool_rel_idx), .alloc_en(pool_alloc), .alloc_ok(pool_ok),
    .alloc_idx(pool_idx), .any_free(pool_free), .used_cnt(pages_used)
  );

  pba_queue #(.DEPTH(NUM_PAGES), .DW(PW), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_s), .clr(txq_clr), .push(txq_push),
    .push_data(pnum_q[PW-1:0]), .pop(txq_pop), .head(txq_head),
    .cnt(txq_cnt), .cnt_nxt(txq_nxt)
  );

  pba_queue #(.DEPTH(NUM_PAGES), .DW(PW), .CW(CW)) u_dnq (
    .clk(clk), .rst_n(rst_s), .clr(dnq_clr), .push(dnq_push),
    .push_data(txq_head), .pop(dnq_pop), .head(dnq_head),
    .cnt(dnq_cnt), .cnt_nxt(dnq_nxt)
  );

  pba_queue #(.DEPTH(NUM_PAGES), .DW(PW), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_s), .clr(rxq_clr), .push(rx_grant),
    .push_data(pool_idx), .pop(rxq_pop), .head(rxq_head),
    .cnt(rxq_cnt), .cnt_nxt(rxq_nxt)
  );

  pba_irq u_irq (
    .clk(clk), .rst_n(rst_s), .set_vec(irq_set), .clr_vec(irq_clr),
    .force_vec(irq_force), .mask_we(mask_we), .mask_data(mask_byte),
    .status(int_status), .mask(int_mask), .irq(irq)
  );

  logic unused_sink;
  assign unused_sink = ^{cmd_byte[OP_LSB-1:0], rxq_nxt};

  assign rx_ack       = rx_grant;
  assign rx_page      = pool_idx;
  assign tx_pending   = (txq_cnt != '0);
  assign tx_page      = txq_head;
  assign pnum         = pnum_q;
  assign alloc_result = res_q;
  assign done_head    = (dnq_cnt == '0) ? EMPTY_CODE : 8'(dnq_head);
  assign rx_head      = (rxq_cnt == '0) ? EMPTY_CODE : 8'(rxq_head);

  // R10
  txempty_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (txq_cnt == '0) |-> int_status[IRQ_TXEMPTY]);

  // R10
  txdone_flag_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (dnq_cnt != '0) |-> int_status[IRQ_TXDONE]);

  // R2
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (res_q != EMPTY_CODE) |-> (res_q < 8'(NUM_PAGES)));

  // R14
  rx_priority_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rx_ack |-> (!cmd_we && !ack_we && !tx_fire));

  // R8
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rx_ack |-> (pages_used != FULL_CNT));

endmodule

// File: tb/pkt_page_mgr_bench.sv
`timescale 1ns/1ps
module pkt_page_mgr_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 0, pnum_we = 0, ack_we = 0, mask_we = 0;
  logic [7:0] cmd_byte = 0, pnum_wdata = 0, ack_byte = 0, mask_byte = 0;
  logic       auto_release = 0, tx_complete = 0, rx_req = 0;
  logic       rx_ack, tx_pending, irq;
  logic [1:0] rx_page, tx_page;
  logic [7:0] pnum, alloc_result, done_head, rx_head, int_status, int_mask;
  logic [2:0] pages_used;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pkt_page_mgr u_pkt_page_mgr (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .pnum_we(pnum_we), .pnum_wdata(pnum_wdata), .ack_we(ack_we),
    .ack_byte(ack_byte), .mask_we(mask_we), .mask_byte(mask_byte),
    .auto_release(auto_release), .tx_complete(tx_complete), .rx_req(rx_req),
    .rx_ack(rx_ack), .rx_page(rx_page), .tx_pending(tx_pending),
    .tx_page(tx_page), .pnum(pnum), .alloc_result(alloc_result),
    .done_head(done_head), .rx_head(rx_head), .pages_used(pages_used),
    .int_status(int_status), .int_mask(int_mask), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic [2:0] code);
    @(negedge clk); cmd_we = 1; cmd_byte = {code, 5'b10101};
    @(negedge clk); cmd_we = 0; cmd_byte = 0;
  endtask

  task automatic setp(input logic [7:0] v);
    @(negedge clk); pnum_we = 1; pnum_wdata = v;
    @(negedge clk); pnum_we = 0;
  endtask

  task automatic ack(input logic [7:0] v);
    @(negedge clk); ack_we = 1; ack_byte = v;
    @(negedge clk); ack_we = 0; ack_byte = 0;
  endtask

  task automatic setmask(input logic [7:0] v);
    @(negedge clk); mask_we = 1; mask_byte = v;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic txdone();
    @(negedge clk); tx_complete = 1;
    @(negedge clk); tx_complete = 0;
  endtask

  task automatic rxget(input logic exp_ack, input logic [1:0] exp_page);
    @(negedge clk); rx_req = 1; #1;
    chk("R8 rx_ack", rx_ack, exp_ack);
    if (exp_ack) chk("R8 rx_page", rx_page, exp_page);
    @(negedge clk); rx_req = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 alloc_result", alloc_result, 8'h00);
    chk("R1 done_head", done_head, 8'h80);
    chk("R1 rx_head", rx_head, 8'h80);
    chk("R1 pages_used", pages_used, 0);
    chk("R1 int_status", int_status, 8'h04);
    chk("R1 int_mask", int_mask, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 tx_pending", tx_pending, 0);

    // R12 mask sweep with status 0x04
    for (int m = 0; m < 256; m++) begin
      setmask(8'(m));
      chk("R12 irq", irq, (m >> 2) & 1);
    end
    setmask(8'h00);

    // R2 R3 R4 exhaustive occupancy sweep
    for (int m = 0; m < 16; m++) begin
      op(3'd2);
      for (int k = 0; k < 4; k++) begin
        op(3'd1);
        chk("R2 lowest free", alloc_result, k);
      end
      for (int p = 0; p < 4; p++) begin
        if (((m >> p) & 1) == 0) begin setp(8'(p)); op(3'd5); end
      end
      chk("R2 pages_used", pages_used, $countones(4'(m)));
      op(3'd0);
      chk("R4 no-op", pages_used, $countones(4'(m)));
      op(3'd1);
      exp = 8'h80;
      for (int p = 3; p >= 0; p--) if (((m >> p) & 1) == 0) exp = 8'(p);
      chk("R3 alloc result", alloc_result, exp);
      chk("R3 alloc flag", int_status[3], (m != 15));
      if (m == 15) begin
        setp(8'd2); op(3'd5);
        chk("R3 retry page", alloc_result, 8'd2);
        chk("R3 retry flag", int_status[3], 1);
        chk("R3 retry used", pages_used, 4);
      end
    end

    // R5 invalid release
    op(3'd2); op(3'd1); op(3'd1);
    setp(8'd4); op(3'd5);
    chk("R5 release 4 ignored", pages_used, 2);
    setp(8'hF1); op(3'd5);
    chk("R5 release F1 ignored", pages_used, 2);
    setp(8'd4); op(3'd6);
    chk("R5 push 4 ignored", tx_pending, 0);
    setp(8'd1); op(3'd5);
    chk("R5 valid release", pages_used, 1);

    // R6 R10 R11 transmit path
    op(3'd2); op(3'd1); op(3'd1);
    chk("R10 txempty set", int_status[2], 1);
    setp(8'd0); op(3'd6);
    chk("R6 tx_pending", tx_pending, 1);
    chk("R6 tx_page", tx_page, 0);
    ack(8'h04);
    chk("R11 txempty acked", int_status[2], 0);
    setp(8'd1); op(3'd6);
    txdone();
    chk("R6 tx head next", tx_page, 1);
    chk("R6 done head", done_head, 8'h00);
    chk("R10 txdone set", int_status[1], 1);
    txdone();
    chk("R10 txempty forced", int_status[2], 1);
    chk("R6 done head kept", done_head, 8'h00);
    ack(8'h02);
    chk("R11 done pop", done_head, 8'h01);
    chk("R10 txdone held", int_status[1], 1);
    ack(8'h02);
    chk("R11 done empty", done_head, 8'h80);
    chk("R11 txdone cleared", int_status[1], 0);
    ack(8'h02);
    chk("R7 empty done pop", done_head, 8'h80);
    chk("R6 no release", pages_used, 2);
    setp(8'd0); op(3'd6);
    auto_release = 1;
    txdone();
    auto_release = 0;
    chk("R6 auto release", pages_used, 1);
    chk("R6 auto bypass", done_head, 8'h80);
    op(3'd1);
    chk("R2 realloc", alloc_result, 8'h00);
    ack(8'hFF);
    chk("R11 ack mask", int_status, 8'h0C);
    setmask(8'h08);
    chk("R12 irq alloc", irq, 1);
    setmask(8'h10);
    chk("R12 irq none", irq, 0);
    setmask(8'h00);

    // R14 ack and completion in one cycle
    setp(8'd0); op(3'd6);
    @(negedge clk); ack_we = 1; ack_byte = 8'h00; tx_complete = 1;
    @(negedge clk); ack_we = 0; tx_complete = 0;
    chk("R14 completion blocked", tx_pending, 1);
    op(3'd7);

    // R8 R9 receive path
    op(3'd2);
    rxget(1, 2'd0);
    chk("R8 rx head", rx_head, 8'h00);
    chk("R8 rx flag", int_status[0], 1);
    rxget(1, 2'd1);
    rxget(1, 2'd2);
    rxget(1, 2'd3);
    chk("R8 used full", pages_used, 4);
    rxget(0, 2'd0);
    op(3'd3);
    chk("R9 pop head", rx_head, 8'h01);
    chk("R9 pop keeps page", pages_used, 4);
    chk("R9 flag held", int_status[0], 1);
    op(3'd4);
    chk("R9 poprel head", rx_head, 8'h02);
    chk("R9 poprel used", pages_used, 3);
    op(3'd4);
    op(3'd4);
    chk("R9 empty head", rx_head, 8'h80);
    chk("R9 used", pages_used, 1);
    chk("R9 flag cleared", int_status[0], 0);
    op(3'd3);
    chk("R7 empty rx pop", pages_used, 1);
    op(3'd4);
    chk("R7 empty rx poprel", pages_used, 1);

    // R14 command and receive in one cycle
    @(negedge clk); cmd_we = 1; cmd_byte = 8'h00; rx_req = 1; #1;
    chk("R14 rx blocked", rx_ack, 0);
    @(negedge clk); cmd_we = 0; rx_req = 0;
    chk("R14 rx queue", rx_head, 8'h80);

    // R13 clear commands
    op(3'd1);
    setp(8'd1); op(3'd6);
    txdone();
    setp(8'd0); op(3'd6);
    chk("R13 setup done", done_head, 8'h01);
    op(3'd7);
    chk("R13 tx cleared", tx_pending, 0);
    chk("R13 done cleared", done_head, 8'h80);
    chk("R13 bitmap kept", pages_used, 2);
    op(3'd2);
    chk("R13 reset used", pages_used, 0);
    chk("R13 reset result", alloc_result, 8'h00);

    done = 1;
    finish_run();
  end

endmodule